// File: doc/BRIEF.md
# Power-Good, Overvoltage and Interrupt Monitor

This block sits behind the feedback-voltage window comparators of a buck-boost controller. It turns their digitised results into two supervised states: power-good and overvoltage fault. Power-good is slow to assert and quick to drop. It rises only after the feedback voltage has stayed inside the tight window for a long, parameterised time. It falls once the feedback voltage has stayed outside the wider window across two switching-cycle strobes. The overvoltage fault is qualified over switching cycles in the same way. It is blanked while the reference is ramping and stays disarmed from reset until a programmable delay after soft start completes. While the fault is set, the block asks the converter for its reduced fault frequency, and the fault output itself tells the gate drivers to hold the input high-side switch off and the input low-side switch on.

The block also holds a six-bit interrupt acknowledge register. Each source has its own bit, and a per-bit mask keeps a source from ever setting its bit. While any bit is set, an active-low open-drain style pin is pulled low. A read strobe clears the register and releases the pin. All interfaces are plain control and status pins: the block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pgmon_top`

## Requirements
- R1: `pg` rises after `fb_in_win5` has been high for `PG_QUAL_CYCLES` consecutive clock cycles, counted from the first cycle it is seen high. A single low cycle restarts the count.
- R2: Once `pg` is high, it falls at the second consecutive `sw_stb` seen with `fb_out_win7` high. A single such strobe does not clear `pg`, and neither does any time spent between the two windows (both inputs low).
- R3: `ov_fault` sets at the second consecutive `sw_stb` seen with `fb_above_ov` high, provided `fb_above_ov` stays high between the two strobes. It clears at the first strobe seen with `fb_above_ov` low. `freq_drop_req` is high exactly while `ov_fault` is high, and `ov_fault` commands the input high-side switch off and the input low-side switch on.
- R4: While `ref_slewing` is high, `ov_fault` is held clear and strobe qualification is discarded.
- R5: From reset, OV detection is disarmed. It arms `OV_REARM_CYCLES` clock cycles after an `ss_done` pulse.
- R6: `pg_mask`=1 forces the `pg` output low and suppresses the power-loss interrupt. `ov_mask`=1 holds `ov_fault` and `freq_drop_req` clear.
- R7: `ack` bit positions: 0 = power-good lost, 1 = OV fault raised, 2 = `evt_therm`, 3 = `evt_ilim`, 4 = `evt_xlim`, 5 = `evt_vneg`. A source sets its bit one cycle after the event. `int_n` is 0 while any bit is set and 1 otherwise.
- R8: When `irq_mask[i]`=1, bit i of `ack` never sets.
- R9: A cycle with `rd_stb`=1 clears `ack` at the next edge. An unmasked event in the same cycle leaves its bit set.
- R10: After reset, `pg`, `ov_fault` and `freq_drop_req` are 0, `ack` is 0 and `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_in_win5 | input | 1 | Feedback inside the ±5% window |
| fb_out_win7 | input | 1 | Feedback outside the ±7% window |
| fb_above_ov | input | 1 | Feedback above the overvoltage threshold |
| sw_stb | input | 1 | One-cycle pulse per switching cycle |
| ref_slewing | input | 1 | Reference is ramping |
| ss_done | input | 1 | One-cycle pulse when soft start completes |
| evt_therm | input | 1 | Thermal trip event |
| evt_ilim | input | 1 | Internal current-limit event |
| evt_xlim | input | 1 | External current-limit event |
| evt_vneg | input | 1 | Downward voltage-change event |
| rd_stb | input | 1 | Acknowledge register read (clear) |
| irq_mask | input | 6 | Per-source interrupt mask, 1 = blocked |
| pg_mask | input | 1 | Masks power-good output and its interrupt |
| ov_mask | input | 1 | Masks overvoltage action |
| pg | output | 1 | Power-good |
| ov_fault | output | 1 | Overvoltage fault (S1 off, S2 on) |
| freq_drop_req | output | 1 | Request for reduced switching frequency |
| ack | output | 6 | Interrupt acknowledge register |
| int_n | output | 1 | Interrupt pin, active low, open-drain style |

## Verification
A table of event and mask combinations exercises the interrupt register. It separates a correct mask from an inverted one and shows that each source lands on its own bit position. Power-good is driven with an interrupted qualifying run, a dwell between the two windows and a single out-of-window strobe. Each of these tells a true continuity check apart from a plain accumulating counter or a single-strobe drop. Overvoltage is tried before arming, inside the re-arm delay, while slewing and while masked, which isolates each blanking path. A read that coincides with a new event confirms that the clear does not swallow that event.

// File: rtl/pgmon_pkg.sv
package pgmon_pkg;
  localparam int NSRC = 6;
  typedef enum int {
    SRC_PG_LOSS = 0,
    SRC_OV      = 1,
    SRC_THERM   = 2,
    SRC_ILIM    = 3,
    SRC_XLIM    = 4,
    SRC_VNEG    = 5
  } src_e;
endpackage

// File: rtl/pgmon_pg_qual.sv
module pgmon_pg_qual #(
  parameter int unsigned QUAL_CYCLES = 660000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_win,
  input  logic out_win,
  input  logic sw_stb,
  output logic pg_state
);
  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);
  localparam logic [CW-1:0] SAT  = CW'(QUAL_CYCLES);

  logic [CW-1:0] dwell;
  logic          drop_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell      <= '0;
      drop_armed <= 1'b0;
      pg_state   <= 1'b0;
    end else begin
      // continuous dwell inside the tight window
      if (!in_win) dwell <= '0;
      else if (dwell != SAT) dwell <= dwell + 1'b1;

      if (!pg_state && in_win && dwell == LAST) pg_state <= 1'b1;

      // drop-out needs two strobes outside the wide window in a row
      if (!out_win) drop_armed <= 1'b0;
      else if (sw_stb) begin
        if (drop_armed) pg_state <= 1'b0;
        drop_armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgmon_ov_guard.sv
module pgmon_ov_guard #(
  parameter int unsigned REARM_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above,
  input  logic sw_stb,
  input  logic slewing,
  input  logic ss_done,
  input  logic ov_mask,
  output logic ov_fault
);
  localparam int unsigned RW = $clog2(REARM_CYCLES + 1);
  localparam logic [RW-1:0] RLAST = RW'(REARM_CYCLES - 1);

  logic [RW-1:0] wait_cnt;
  logic          waiting;
  logic          armed_ok;
  logic          hit_armed;
  logic          enable;

  assign enable = armed_ok && !slewing && !ov_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      waiting  <= 1'b0;
      armed_ok <= 1'b0;
    end else if (ss_done) begin
      wait_cnt <= '0;
      waiting  <= 1'b1;
      armed_ok <= 1'b0;
    end else if (waiting) begin
      wait_cnt <= wait_cnt + 1'b1;
      if (wait_cnt == RLAST) begin
        waiting  <= 1'b0;
        armed_ok <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_armed <= 1'b0;
      ov_fault  <= 1'b0;
    end else if (!enable) begin
      hit_armed <= 1'b0;
      ov_fault  <= 1'b0;
    end else begin
      if (!above) hit_armed <= 1'b0;
      if (sw_stb) begin
        if (above) begin
          if (hit_armed) ov_fault <= 1'b1;
          hit_armed <= 1'b1;
        end else begin
          ov_fault <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pgmon_irq_reg.sv
module pgmon_irq_reg
  import pgmon_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] mask,
  input  logic            rd,
  output logic [NSRC-1:0] ack
);
  logic [NSRC-1:0] nxt;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
      // a read clears old state; a same-cycle event survives
      assign nxt[i] = (ack[i] && !rd) || (ev[i] && !mask[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= '0;
    else        ack <= nxt;
  end
endmodule

// File: rtl/pgmon_top.sv
module pgmon_top
  import pgmon_pkg::*;
#(
  parameter int unsigned PG_QUAL_CYCLES  = 660000,
  parameter int unsigned OV_REARM_CYCLES = 200000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fb_in_win5,
  input  logic            fb_out_win7,
  input  logic            fb_above_ov,
  input  logic            sw_stb,
  input  logic            ref_slewing,
  input  logic            ss_done,
  input  logic            evt_therm,
  input  logic            evt_ilim,
  input  logic            evt_xlim,
  input  logic            evt_vneg,
  input  logic            rd_stb,
  input  logic [NSRC-1:0] irq_mask,
  input  logic            pg_mask,
  input  logic            ov_mask,
  output logic            pg,
  output logic            ov_fault,
  output logic            freq_drop_req,
  output logic [NSRC-1:0] ack,
  output logic            int_n
);
  logic            pg_state, pg_state_q, ov_q;
  logic [NSRC-1:0] ev;

  pgmon_pg_qual #(.QUAL_CYCLES(PG_QUAL_CYCLES)) u_pg (
    .clk(clk), .rst_n(rst_n), .in_win(fb_in_win5), .out_win(fb_out_win7),
    .sw_stb(sw_stb), .pg_state(pg_state)
  );

  pgmon_ov_guard #(.REARM_CYCLES(OV_REARM_CYCLES)) u_ov (
    .clk(clk), .rst_n(rst_n), .above(fb_above_ov), .sw_stb(sw_stb),
    .slewing(ref_slewing), .ss_done(ss_done), .ov_mask(ov_mask),
    .ov_fault(ov_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_state_q <= 1'b0;
      ov_q       <= 1'b0;
    end else begin
      pg_state_q <= pg_state;
      ov_q       <= ov_fault;
    end
  end

  assign ev[SRC_PG_LOSS] = pg_state_q && !pg_state && !pg_mask;
  assign ev[SRC_OV]      = ov_fault && !ov_q;
  assign ev[SRC_THERM]   = evt_therm;
  assign ev[SRC_ILIM]    = evt_ilim;
  assign ev[SRC_XLIM]    = evt_xlim;
  assign ev[SRC_VNEG]    = evt_vneg;

  pgmon_irq_reg u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .mask(irq_mask), .rd(rd_stb), .ack(ack)
  );

  assign pg            = pg_state && !pg_mask;
  assign freq_drop_req = ov_fault;
  assign int_n         = ~(|ack);
endmodule

// File: rtl/pgmon_checker.sv
module pgmon_checker
  import pgmon_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            fb_in_win5,
  input logic            fb_out_win7,
  input logic            fb_above_ov,
  input logic            sw_stb,
  input logic            ref_slewing,
  input logic            ov_mask,
  input logic            pg_mask,
  input logic            rd_stb,
  input logic            evt_therm,
  input logic            evt_ilim,
  input logic            evt_xlim,
  input logic            evt_vneg,
  input logic [NSRC-1:0] irq_mask,
  input logic            pg,
  input logic            ov_fault,
  input logic [NSRC-1:0] ack
);
  assert_pg_rise_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pg) && !$past(pg_mask)) |-> $past(fb_in_win5));

  assert_pg_fall_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pg) && !pg_mask) |-> $past(sw_stb && fb_out_win7));

  assert_ov_set_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_fault) |-> $past(sw_stb && fb_above_ov && !ref_slewing));

  assert_ov_blank_slew_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_slewing |=> !ov_fault);

  assert_ov_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_mask |=> !ov_fault);

  assert_masked_bit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(ack & ~$past(ack) & $past(irq_mask))));

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ack[5:2] == $past({evt_vneg, evt_xlim, evt_ilim, evt_therm} & ~irq_mask[5:2]));
endmodule

bind pgmon_top pgmon_checker u_chk (.*);

// File: tb/sim_pgmon_top.sv
module sim_pgmon_top;
  localparam int Q  = 20;
  localparam int RA = 40;

  typedef struct packed {
    logic [3:0] ev;
    logic [5:0] msk;
    logic [5:0] exp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{ev: 4'b0001, msk: 6'b000000, exp: 6'b000100},
    '{ev: 4'b1010, msk: 6'b000000, exp: 6'b101000},
    '{ev: 4'b1111, msk: 6'b111100, exp: 6'b000000},
    '{ev: 4'b0110, msk: 6'b010000, exp: 6'b001000},
    '{ev: 4'b1001, msk: 6'b000100, exp: 6'b100000}
  };

  logic clk = 0, rst_n = 0;
  logic fb_in_win5 = 0, fb_out_win7 = 0, fb_above_ov = 0, sw_stb = 0;
  logic ref_slewing = 0, ss_done = 0, rd_stb = 0, pg_mask = 0, ov_mask = 0;
  logic evt_therm = 0, evt_ilim = 0, evt_xlim = 0, evt_vneg = 0;
  logic [5:0] irq_mask = 0;
  logic pg, ov_fault, freq_drop_req, int_n;
  logic [5:0] ack;
  int errs = 0, nchk = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgmon_top #(.PG_QUAL_CYCLES(Q), .OV_REARM_CYCLES(RA)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) sw_stb = 1;
    @(negedge clk) sw_stb = 0;
  endtask

  task automatic read_clear();
    @(negedge clk) rd_stb = 1;
    @(negedge clk) rd_stb = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; nchk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 pg", pg, 0);
    chk("R10 ov_fault", ov_fault, 0);
    chk("R10 freq_drop_req", freq_drop_req, 0);
    chk("R10 ack", ack, 0);
    chk("R10 int_n", int_n, 1);

    // table walk: R7 bit positions, R8 masks, R9 clear
    foreach (VECS[i]) begin
      @(negedge clk);
      irq_mask = VECS[i].msk;
      {evt_vneg, evt_xlim, evt_ilim, evt_therm} = VECS[i].ev;
      @(negedge clk);
      {evt_vneg, evt_xlim, evt_ilim, evt_therm} = 4'b0;
      chk("R7/R8 ack", ack, VECS[i].exp);
      chk("R7 int_n", int_n, (VECS[i].exp == 0));
      read_clear();
      chk("R9 ack cleared", ack, 0);
      chk("R9 int_n released", int_n, 1);
    end

    // R9 read in same cycle as new event
    irq_mask = 0;
    @(negedge clk) evt_ilim = 1;
    @(negedge clk) evt_ilim = 0;
    chk("R7 ilim bit3", ack, 6'b001000);
    @(negedge clk) begin rd_stb = 1; evt_therm = 1; end
    @(negedge clk) begin rd_stb = 0; evt_therm = 0; end
    chk("R9 same-cycle event kept", ack, 6'b000100);
    read_clear();

    // R1 interrupted run restarts the dwell
    @(negedge clk) fb_in_win5 = 1;
    repeat (Q - 2) @(negedge clk);
    fb_in_win5 = 0;
    @(negedge clk) fb_in_win5 = 1;
    repeat (Q - 1) @(negedge clk);
    chk("R1 pg not yet", pg, 0);
    @(negedge clk);
    chk("R1 pg after dwell", pg, 1);

    // R2 band between windows holds pg
    fb_in_win5 = 0; fb_out_win7 = 0;
    repeat (3) strobe();
    chk("R2 pg held in band", pg, 1);
    fb_out_win7 = 1; strobe();
    chk("R2 single strobe keeps pg", pg, 1);
    fb_out_win7 = 0; strobe();
    fb_out_win7 = 1; strobe();
    chk("R2 non-consecutive keeps pg", pg, 1);
    strobe();
    chk("R2 pg dropped", pg, 0);
    @(negedge clk);
    chk("R7 pg loss bit0", ack, 6'b000001);
    read_clear();

    // R6 pg mask
    fb_out_win7 = 0; fb_in_win5 = 1;
    repeat (Q + 2) @(negedge clk);
    chk("R1 pg requalified", pg, 1);
    pg_mask = 1;
    @(negedge clk);
    chk("R6 pg masked low", pg, 0);
    fb_in_win5 = 0; fb_out_win7 = 1;
    strobe(); strobe();
    @(negedge clk);
    chk("R6 masked loss no irq", ack, 0);
    pg_mask = 0;
    @(negedge clk);
    chk("R6 pg state dropped", pg, 0);
    fb_out_win7 = 0;

    // R5 disarmed before and shortly after soft start
    fb_above_ov = 1;
    repeat (3) strobe();
    chk("R5 no ov before ss_done", ov_fault, 0);
    @(negedge clk) ss_done = 1;
    @(negedge clk) ss_done = 0;
    strobe(); strobe();
    chk("R5 no ov in rearm delay", ov_fault, 0);
    fb_above_ov = 0;
    repeat (RA + 10) @(negedge clk);

    // R3 qualification and clearing
    fb_above_ov = 1;
    strobe();
    chk("R3 one strobe no ov", ov_fault, 0);
    strobe();
    chk("R3 ov set", ov_fault, 1);
    chk("R3 freq drop", freq_drop_req, 1);
    @(negedge clk);
    chk("R7 ov bit1", ack, 6'b000010);
    read_clear();
    fb_above_ov = 0; strobe();
    chk("R3 ov cleared", ov_fault, 0);
    chk("R3 freq drop cleared", freq_drop_req, 0);

    // R4 blanking during slew
    ref_slewing = 1; fb_above_ov = 1;
    repeat (3) strobe();
    chk("R4 no ov while slewing", ov_fault, 0);
    ref_slewing = 0;
    strobe(); strobe();
    chk("R4 ov after slew ends", ov_fault, 1);

    // R6 ov mask
    @(negedge clk) ov_mask = 1;
    @(negedge clk);
    chk("R6 ov masked", ov_fault, 0);
    repeat (3) strobe();
    chk("R6 ov stays masked", freq_drop_req, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule